// File: doc/BRIEF.md
# Mirrored-Bank Register File with Start-Up Clear

This block is a CPU register file for memory fabrics that can only read synchronously. It holds a parameterised number of registers (32 by default, each 32 bits wide) and offers one write port and two read ports. Each read port is served by its own copy of the storage. Every accepted write lands in both copies on the same clock edge, so the two copies always hold the same contents. A read address is captured on a rising edge and its data appears after that edge. No combinational path runs from a read address to read data. When a write and a read target the same register on the same edge, the read returns the value being written.

Memory contents are undefined at power-up, so two copies left alone could disagree about the same register. After reset the block raises `busy` for a fixed hold period. It then walks every address and writes zero to both copies, one address per cycle. Only after that does it drop `busy` for good. The consumer is meant to stay in reset while `busy` is high.

The write port is a valid/ready pair. `wr_ready` is high exactly when `busy` is low, and a write is accepted on an edge where both `wr_valid` and `wr_ready` are high. A write offered while `wr_ready` is low is dropped, not held. The offering side need not keep it stable, because the block never stalls once it is running. The read ports are plain address/data pins with no handshake.

Top module: `regfile_dual_bank`

## Requirements
- R1: `busy` is high during reset. After `rst_n` is released it stays high for exactly HOLD_CYCLES + NREGS rising edges, then goes low and never rises again until the next reset.
- R2: On the first cycles after `busy` falls, every register, register 0 included, reads as zero on both read ports.
- R3: The address on `rd_a_addr` or `rd_b_addr` is captured on a rising edge, and the matching data is valid on that port after that edge until the next one. A value written on one edge is returned by a read captured on any later edge.
- R4: If a write is accepted on the same edge that captures a read of the same address, that port returns the written data (`wr_data`), not the old contents.
- R5: An accepted write updates the register in both copies, so the value is then readable from port A and from port B.
- R6: `wr_ready` equals the inverse of `busy`. Writes offered while `busy` is high change no register, so every register still reads zero after the clear.
- R7: When both read ports capture the same address on the same edge, they return identical data.
- R8: When `wr_valid` is low, the values on `wr_addr` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the start-up sequencer |
| busy | output | 1 | High during the hold period and the clear walk |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted (low while busy) |
| wr_addr | input | $clog2(NREGS) | Register to write |
| wr_data | input | WIDTH | Value to write |
| rd_a_addr | input | $clog2(NREGS) | Read address, port A |
| rd_a_data | output | WIDTH | Read data, port A, one edge after the address |
| rd_b_addr | input | $clog2(NREGS) | Read address, port B |
| rd_b_data | output | WIDTH | Read data, port B, one edge after the address |

## Verification
If the two copies diverge, both ports return different data for the same address one edge after a shared read. A sweep with both ports reading every address exposes this within NREGS cycles. A wrong start-up sequencer shows as a `busy` pulse of the wrong length, or as a nonzero value on the first sweep after `busy` falls. A missing or misrouted bypass shows as stale data in the very cycle after a colliding write. A write that leaks through while busy, or with `wr_valid` low, shows the next time the touched address is read.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  localparam int RF_COPIES = 2;
endpackage

// File: rtl/rf_startup_seq.sv
module rf_startup_seq
  import rf_pkg::*;
#(
  parameter int NREGS       = 32,
  parameter int HOLD_CYCLES = 4096,
  localparam int AW = $clog2(NREGS),
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr
);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(NREGS - 1);

  phase_t        phase;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HOLD;
      hold_cnt <= '0;
      clr_addr <= '0;
    end else begin
      case (phase)
        PH_HOLD: begin
          if (hold_cnt == HOLD_LAST) begin
            phase <= PH_CLEAR;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        PH_CLEAR: begin
          if (clr_addr == ADDR_LAST) begin
            phase <= PH_RUN;
          end else begin
            clr_addr <= clr_addr + 1'b1;
          end
        end
        PH_RUN:  phase <= PH_RUN;
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assign busy   = (phase != PH_RUN);
  assign clr_we = (phase == PH_CLEAR);
endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             busy,
  input  logic             clr_we,
  input  logic [AW-1:0]    clr_addr,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             bank_we,
  output logic [AW-1:0]    bank_waddr,
  output logic [WIDTH-1:0] bank_wdata
);
  always_comb begin
    wr_ready = !busy;
    if (clr_we) begin
      bank_we    = 1'b1;
      bank_waddr = clr_addr;
      bank_wdata = '0;
    end else begin
      bank_we    = wr_valid && !busy;
      bank_waddr = wr_addr;
      bank_wdata = wr_data;
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (we && (waddr == raddr)) begin
      rdata <= wdata;
    end else begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/regfile_dual_bank.sv
module regfile_dual_bank
  import rf_pkg::*;
#(
  parameter int NREGS       = 32,
  parameter int WIDTH       = 32,
  parameter int HOLD_CYCLES = 4096,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_a_addr,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_b_data
);
  logic             clr_we;
  logic [AW-1:0]    clr_addr;
  logic             bank_we;
  logic [AW-1:0]    bank_waddr;
  logic [WIDTH-1:0] bank_wdata;
  logic [AW-1:0]    port_addr [RF_COPIES];
  logic [WIDTH-1:0] port_data [RF_COPIES];

  rf_startup_seq #(
    .NREGS      (NREGS),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .clr_we  (clr_we),
    .clr_addr(clr_addr)
  );

  rf_write_arb #(
    .NREGS(NREGS),
    .WIDTH(WIDTH)
  ) u_arb (
    .busy      (busy),
    .clr_we    (clr_we),
    .clr_addr  (clr_addr),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .bank_we   (bank_we),
    .bank_waddr(bank_waddr),
    .bank_wdata(bank_wdata)
  );

  assign port_addr[0] = rd_a_addr;
  assign port_addr[1] = rd_b_addr;

  for (genvar p = 0; p < RF_COPIES; p++) begin : g_copy
    rf_bank #(
      .NREGS(NREGS),
      .WIDTH(WIDTH)
    ) u_bank (
      .clk  (clk),
      .we   (bank_we),
      .waddr(bank_waddr),
      .wdata(bank_wdata),
      .raddr(port_addr[p]),
      .rdata(port_data[p])
    );
  end

  assign rd_a_data = port_data[0];
  assign rd_b_data = port_data[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NREGS       = 32,
  parameter int WIDTH       = 32,
  parameter int HOLD_CYCLES = 4096,
  localparam int AW = $clog2(NREGS),
  localparam int BUSY_TOTAL = HOLD_CYCLES + NREGS,
  localparam int CW = $clog2(BUSY_TOTAL + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_a_addr,
  input logic [WIDTH-1:0] rd_a_data,
  input logic [AW-1:0]    rd_b_addr,
  input logic [WIDTH-1:0] rd_b_data
);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CW'(BUSY_TOTAL))); // R1

  AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R1

  AST_BYPASS_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (wr_addr == rd_a_addr)) |=> (rd_a_data == $past(wr_data))); // R4

  AST_BYPASS_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (wr_addr == rd_b_addr)) |=> (rd_b_data == $past(wr_data))); // R4

  AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (rd_a_addr == rd_b_addr)) |=> (rd_a_data == rd_b_data)); // R7
endmodule

bind regfile_dual_bank rf_checker #(
  .NREGS      (NREGS),
  .WIDTH      (WIDTH),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_rf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_a_addr(rd_a_addr),
  .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr),
  .rd_b_data(rd_b_data)
);

// File: tb/regfile_dual_bank_bench.sv
`timescale 1ns/100ps
module regfile_dual_bank_bench;
  localparam int NREGS = 32;
  localparam int WIDTH = 32;
  localparam int HOLD  = 4096;
  localparam int AW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             busy, wr_ready;
  logic             wr_valid = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [AW-1:0]    rd_a_addr = '0, rd_b_addr = '0;
  logic [WIDTH-1:0] rd_a_data, rd_b_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] model [NREGS];

  always #2.5 clk = ~clk;

  regfile_dual_bank #(
    .NREGS(NREGS), .WIDTH(WIDTH), .HOLD_CYCLES(HOLD)
  ) u_regfile_dual_bank (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  task automatic check(input string tag, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] pattern(input int idx, input int round);
    return (WIDTH'(idx + 1) * 32'h9E37_79B1) ^ (WIDTH'(round) << 24) ^ 32'h0000_5A5A;
  endfunction

  // Drive one cycle at the falling edge, sample just after the rising edge.
  task automatic step(input logic we, input int wa, input logic [WIDTH-1:0] wd,
                      input int ra, input int rb, input string tag);
    logic [WIDTH-1:0] exp_a, exp_b;
    @(negedge clk);
    wr_valid  = we;
    wr_addr   = AW'(wa);
    wr_data   = wd;
    rd_a_addr = AW'(ra);
    rd_b_addr = AW'(rb);
    exp_a = (we && wa == ra) ? wd : model[ra];
    exp_b = (we && wa == rb) ? wd : model[rb];
    @(posedge clk);
    #1;
    if (we) model[wa] = wd;
    check({tag, " port A"}, rd_a_data, exp_a);
    check({tag, " port B"}, rd_b_data, exp_b);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int busy_len;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 32'd1);
    check("R6 ready in reset", {31'd0, wr_ready}, 32'd0);

    // Release reset and offer writes the whole time busy is high.
    rst_n = 1'b1;
    busy_len = 0;
    while (busy && busy_len < HOLD + NREGS + 10) begin
      check("R6 ready low while busy", {31'd0, wr_ready}, 32'd0);
      busy_len++;
      wr_valid = 1'b1;
      wr_addr  = AW'(busy_len);
      wr_data  = 32'hDEAD_0000 | WIDTH'(busy_len);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    check("R1 busy length", WIDTH'(busy_len), WIDTH'(HOLD + NREGS));
    check("R6 ready after busy", {31'd0, wr_ready}, 32'd1);

    // R2 and R6: every register is zero on both ports after the clear.
    for (int i = 0; i < NREGS; i++) step(1'b0, 0, '0, i, NREGS - 1 - i, "R2 zero sweep");

    // R5: fill every register, reading neighbours to check R3 latency.
    for (int i = 0; i < NREGS; i++)
      step(1'b1, i, pattern(i, 1), (i + 1) % NREGS, (i + NREGS - 1) % NREGS, "R5 fill");
    for (int i = 0; i < NREGS; i++) step(1'b0, 0, '0, i, NREGS - 1 - i, "R3 readback");

    // R4: write and read the same address on the same edge, both ports.
    for (int i = 0; i < NREGS; i++) step(1'b1, i, pattern(i, 2), i, i, "R4 bypass both");
    // R4 on port A only, port B reads an unrelated register.
    for (int i = 0; i < NREGS; i++)
      step(1'b1, i, pattern(i, 3), i, (i + 5) % NREGS, "R4 bypass A");
    // R4 on port B only.
    for (int i = 0; i < NREGS; i++)
      step(1'b1, i, pattern(i, 4), (i + 9) % NREGS, i, "R4 bypass B");

    // R8: wr_valid low with live address and data has no effect.
    for (int i = 0; i < NREGS; i++) step(1'b0, i, 32'hFFFF_FFFF, i, i, "R8 idle write");

    // R7: identical addresses on both ports after a fresh fill.
    for (int i = 0; i < NREGS; i++) step(1'b1, i, pattern(i, 5), 0, 0, "R7 fill");
    for (int i = 0; i < NREGS; i++) step(1'b0, 0, '0, i, i, "R7 same address");

    // R5: back-to-back writes to one register, read on the following edge.
    step(1'b1, 17, 32'h1111_1111, 3, 4, "R5 burst");
    step(1'b1, 17, 32'h2222_2222, 17, 0, "R4 burst");
    step(1'b0, 0, '0, 0, 17, "R5 burst readback");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule